// File: doc/BRIEF.md
# Command Request and Completion Handshake

This block sits between a host and a set of operation engines. It holds a writable 8-bit command-request register and a read-only 8-bit response register. The five low bits of the request byte each name an operation: transmit-frame confirmation, error-number clear, restore defaults, system set and interruption. Writing a 1 to a request bit queues that operation. The block starts one operation at a time with a single-cycle start pulse to its engine, and waits for that engine's done pulse.

The response byte carries one completion flag per operation, and the host polls that flag. A new accepted request for an operation clears its completion flag, and the engine's done pulse sets it again. The three high response bits report whether an engine is running, whether requests are waiting behind a running engine, and whether any accepted command has not yet completed. When several requests are waiting, they run in fixed order, lowest bit first.

The restore-defaults operation is handled in two steps. Once its engine has finished, the block holds the restored settings back until the host issues a separate reset command. That command then produces one load pulse carrying transmission mode A and the default I/O control count.

Top module: `cmd_handshake`

## Requirements
- R1: After reset, `req_rd` and `rsp_rd` read 0x00, and `op_start` and `dflt_load` are low.
- R2: A host write with bit i set (i in 0..4; 0 = frame confirm, 1 = error clear, 2 = defaults, 3 = system set, 4 = interruption) is accepted when operation i is neither queued nor running. From the next cycle, bit i of `req_rd` is 1 and completion bit i of `rsp_rd` is 0.
- R3: A write has no effect in two cases. Bits 5 to 7 of a write are always ignored. A write of bit i is also ignored while operation i is queued or running: no second start follows, and its completion bit is not cleared.
- R4: At most one operation runs at a time. When no operation is running and requests are queued, the lowest-numbered queued request starts in the next cycle. Its `op_start` bit is high for exactly one cycle.
- R5: An `op_done` bit for the running operation ends that operation and sets its completion bit in `rsp_rd` from the next cycle. An `op_done` bit for an operation that is not running is ignored.
- R6: `rsp_rd` bit 5 (busy) is 1 exactly while an operation is running.
- R7: `rsp_rd` bit 6 (on hold) is 1 while an operation is running and at least one other request is queued.
- R8: `rsp_rd` bit 7 (executing) is 1 from the cycle after a request is accepted until that request's completion bit is set, and stays 1 while any accepted request is incomplete.
- R9: After the defaults operation (bit 2) completes, the next `apply_rst` pulse gives a one-cycle `dflt_load` in the following cycle, with `dflt_mode` = 0 (mode A) and `dflt_count` = DFLT_COUNT (512). An `apply_rst` without a finished defaults operation since the last load gives no pulse.
- R10: A completion bit stays set until a new accepted request for its own operation clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the request register |
| host_wdata | input | 8 | Host write data for the request register |
| apply_rst | input | 1 | Host reset command that commits restored defaults |
| op_done | input | 5 | Done pulses from the five operation engines |
| op_start | output | 5 | One-cycle start pulses to the five operation engines |
| req_rd | output | 8 | Request register readout (queued or running operations) |
| rsp_rd | output | 8 | Response register: completions [4:0], busy [5], on hold [6], executing [7] |
| dflt_load | output | 1 | One-cycle pulse that commits default settings |
| dflt_mode | output | 1 | Default transmission mode (0 = mode A) |
| dflt_count | output | 10 | Default I/O control count |

## Verification
The bench builds the block with its default parameters: five operations, a 10-bit count and a default count of 512. With these values it can write every one of the 32 request-bit combinations from idle. For each combination it follows the complete start order and checks the busy and on-hold flags at every start. It also tracks the completion flags that earlier combinations left set. Separate sequences cover a rewrite of a running operation, writes to the unused bits, stray done pulses, and the defaults commit both before and after the defaults operation has run.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    localparam int OP_N   = 5;
    localparam int WORD_W = 8;

    typedef enum logic [2:0] {
        OP_FRAME  = 3'd0,
        OP_ERRCLR = 3'd1,
        OP_DFLT   = 3'd2,
        OP_SYSSET = 3'd3,
        OP_INTR   = 3'd4
    } op_e;

    typedef logic [OP_N-1:0] opvec_t;

    typedef struct packed {
        logic   exec;
        logic   hold;
        logic   busy;
        opvec_t done;
    } rsp_t;

    function automatic opvec_t lowest_bit(opvec_t v);
        return v & (~v + opvec_t'(1));
    endfunction
endpackage

// File: rtl/cmd_req_latch.sv
module cmd_req_latch
    import cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  opvec_t wr_bits,
    input  opvec_t active,
    input  opvec_t issue,
    output opvec_t pending,
    output opvec_t accept
);
    always_comb begin
        accept = '0;
        if (wr_en) accept = wr_bits & ~pending & ~active;
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~issue) | accept;
    end

    assert_rewrite_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((wr_bits & active) != '0)) |=> ((pending & $past(wr_bits & active)) == '0));

    assert_issue_from_queue_R4: assert property (@(posedge clk) disable iff (rst)
        ((issue & ~pending) == '0));
endmodule

// File: rtl/cmd_sched.sv
module cmd_sched
    import cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opvec_t pending,
    input  opvec_t op_done,
    output opvec_t active,
    output opvec_t issue,
    output opvec_t start_q,
    output opvec_t fin
);
    assign fin   = active & op_done;
    assign issue = (active == '0) ? lowest_bit(pending) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '0;
            start_q <= '0;
        end else begin
            active  <= (active & ~fin) | issue;
            start_q <= issue;
        end
    end

    assert_single_run_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));

    assert_start_was_queued_R4: assert property (@(posedge clk) disable iff (rst)
        ((start_q & ~$past(pending)) == '0));

    assert_start_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (start_q != '0) |=> (start_q == '0));
endmodule

// File: rtl/cmd_status.sv
module cmd_status
    import cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opvec_t accept,
    input  opvec_t fin,
    input  opvec_t pending,
    input  opvec_t active,
    output rsp_t   rsp
);
    opvec_t done_q;

    for (genvar i = 0; i < OP_N; i++) begin : g_done
        always_ff @(posedge clk) begin
            if (rst)            done_q[i] <= 1'b0;
            else if (fin[i])    done_q[i] <= 1'b1;
            else if (accept[i]) done_q[i] <= 1'b0;
        end
    end

    always_comb begin
        rsp.done = done_q;
        rsp.busy = (active != '0);
        rsp.hold = (active != '0) && (pending != '0);
        rsp.exec = (active != '0) || (pending != '0);
    end

    assert_accept_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (accept != '0) |=> ((done_q & $past(accept)) == '0));

    assert_set_only_on_finish_R5: assert property (@(posedge clk) disable iff (rst)
        ((done_q & ~$past(done_q) & ~$past(fin)) == '0));

    assert_persist_R10: assert property (@(posedge clk) disable iff (rst)
        ((~done_q & $past(done_q) & ~$past(accept)) == '0));
endmodule

// File: rtl/cmd_dflt_stage.sv
module cmd_dflt_stage #(
    parameter int CNT_W      = 10,
    parameter int DFLT_COUNT = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dflt_fin,
    input  logic             apply_rst,
    output logic             load_q,
    output logic             mode_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] COUNT_INIT = CNT_W'(DFLT_COUNT);
    localparam logic             MODE_A     = 1'b0;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            load_q <= 1'b0;
        end else begin
            load_q <= apply_rst && armed;
            if (dflt_fin)       armed <= 1'b1;
            else if (apply_rst) armed <= 1'b0;
        end
    end

    assign mode_o  = MODE_A;
    assign count_o = COUNT_INIT;

    assert_load_needs_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        load_q |-> $past(apply_rst));

    assert_load_single_R9: assert property (@(posedge clk) disable iff (rst)
        load_q |=> !load_q);
endmodule

// File: rtl/cmd_handshake.sv
module cmd_handshake
    import cmd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DFLT_COUNT = 512
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [WORD_W-1:0]   host_wdata,
    input  logic                apply_rst,
    input  logic [OP_N-1:0]     op_done,
    output logic [OP_N-1:0]     op_start,
    output logic [WORD_W-1:0]   req_rd,
    output logic [WORD_W-1:0]   rsp_rd,
    output logic                dflt_load,
    output logic                dflt_mode,
    output logic [CNT_W-1:0]    dflt_count
);
    opvec_t pending, accept, active, issue, start_q, fin;
    rsp_t   rsp;
    logic   unused_hi;

    assign unused_hi = ^host_wdata[WORD_W-1:OP_N];

    cmd_req_latch u_latch (
        .clk(clk), .rst(rst), .wr_en(host_wr), .wr_bits(host_wdata[OP_N-1:0]),
        .active(active), .issue(issue), .pending(pending), .accept(accept)
    );

    cmd_sched u_sched (
        .clk(clk), .rst(rst), .pending(pending), .op_done(op_done),
        .active(active), .issue(issue), .start_q(start_q), .fin(fin)
    );

    cmd_status u_status (
        .clk(clk), .rst(rst), .accept(accept), .fin(fin),
        .pending(pending), .active(active), .rsp(rsp)
    );

    cmd_dflt_stage #(.CNT_W(CNT_W), .DFLT_COUNT(DFLT_COUNT)) u_dflt (
        .clk(clk), .rst(rst), .dflt_fin(fin[int'(OP_DFLT)]), .apply_rst(apply_rst),
        .load_q(dflt_load), .mode_o(dflt_mode), .count_o(dflt_count)
    );

    assign op_start = start_q;
    assign req_rd   = {{(WORD_W-OP_N){1'b0}}, pending | active};
    assign rsp_rd   = rsp;

    assert_busy_matches_start_R6: assert property (@(posedge clk) disable iff (rst)
        (op_start != '0) |-> rsp_rd[OP_N]);

    assert_exec_covers_queue_R8: assert property (@(posedge clk) disable iff (rst)
        (req_rd != '0) |-> rsp_rd[WORD_W-1]);
endmodule

// File: tb/cmd_handshake_tb_top.sv
module cmd_handshake_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic       apply_rst;
    logic [4:0] op_done;
    logic [4:0] op_start;
    logic [7:0] req_rd;
    logic [7:0] rsp_rd;
    logic       dflt_load;
    logic       dflt_mode;
    logic [9:0] dflt_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cmd_handshake dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .apply_rst(apply_rst), .op_done(op_done), .op_start(op_start),
        .req_rd(req_rd), .rsp_rd(rsp_rd), .dflt_load(dflt_load),
        .dflt_mode(dflt_mode), .dflt_count(dflt_count)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        nedge();
        host_wr = 1'b0; host_wdata = 8'h00;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [4:0] exp_done;
        logic [4:0] remaining;
        rst = 1'b1; host_wr = 1'b0; host_wdata = 8'h00; apply_rst = 1'b0; op_done = 5'h00;
        repeat (3) nedge();
        rst = 1'b0;
        chk("R1 req", 16'(req_rd), 16'h00);
        chk("R1 rsp", 16'(rsp_rd), 16'h00);
        chk("R1 start", 16'(op_start), 16'h00);
        chk("R1 load", 16'(dflt_load), 16'h0);

        // R9: commit without a finished defaults operation
        apply_rst = 1'b1; nedge(); apply_rst = 1'b0;
        chk("R9 unarmed load", 16'(dflt_load), 16'h0);

        // Sweep every request combination from idle
        exp_done = 5'h00;
        for (int m = 0; m < 32; m++) begin
            host_write(8'(m));
            exp_done = exp_done & ~5'(m);
            remaining = 5'(m);
            chk("R2 req readout", 16'(req_rd), 16'(m));
            chk("R8 after accept", 16'(rsp_rd), 16'({(m != 0), 2'b00, exp_done}));
            for (int b = 0; b < 5; b++) begin
                if (m[b]) begin
                    nedge();
                    remaining[b] = 1'b0;
                    chk("R4 start order", 16'(op_start), 16'(5'b1 << b));
                    chk("R6 R7 R8 flags", 16'(rsp_rd[7:5]), 16'({1'b1, (remaining != 0), 1'b1}));
                    op_done = 5'b1 << b;
                    nedge();
                    op_done = 5'h00;
                    exp_done[b] = 1'b1;
                    chk("R5 completion", 16'(rsp_rd[4:0]), 16'(exp_done));
                    chk("R6 idle after done", 16'(rsp_rd[5]), 16'h0);
                end
            end
            nedge();
            chk("R8 R10 final", 16'(rsp_rd), 16'({3'b000, exp_done}));
            chk("R4 no extra start", 16'(op_start), 16'h00);
        end

        // R9: defaults finished during sweep, now commit
        apply_rst = 1'b1; nedge(); apply_rst = 1'b0;
        chk("R9 load", 16'(dflt_load), 16'h1);
        chk("R9 mode", 16'(dflt_mode), 16'h0);
        chk("R9 count", 16'(dflt_count), 16'd512);
        nedge();
        chk("R9 single", 16'(dflt_load), 16'h0);
        apply_rst = 1'b1; nedge(); apply_rst = 1'b0;
        chk("R9 disarmed", 16'(dflt_load), 16'h0);

        // R3: unused bits ignored
        host_write(8'hE0);
        chk("R3 unused req", 16'(req_rd), 16'h00);
        chk("R3 unused rsp", 16'(rsp_rd), 16'h1F);
        nedge();
        chk("R3 unused start", 16'(op_start), 16'h00);

        // R3: rewrite while running
        host_write(8'h01);
        chk("R2 accept", 16'(rsp_rd), 16'h9E);
        nedge();
        chk("R4 start bit0", 16'(op_start), 16'h01);
        host_write(8'h01);
        chk("R3 rewrite req", 16'(req_rd), 16'h01);
        chk("R3 rewrite rsp", 16'(rsp_rd), 16'hBE);
        // R5: stray done ignored
        op_done = 5'h02; nedge(); op_done = 5'h00;
        chk("R5 stray done", 16'(rsp_rd), 16'hBE);
        op_done = 5'h01; nedge(); op_done = 5'h00;
        chk("R5 real done", 16'(rsp_rd), 16'h1F);
        nedge();
        chk("R3 no rerun", 16'(op_start), 16'h00);
        chk("R10 persist", 16'(rsp_rd), 16'h1F);

        // R7: queue behind a running op
        host_write(8'h01);
        nedge();
        host_write(8'h18);
        chk("R7 hold", 16'(rsp_rd[7:5]), 16'h7);
        op_done = 5'h01; nedge(); op_done = 5'h00;
        nedge();
        chk("R4 next lowest", 16'(op_start), 16'h08);
        op_done = 5'h08; nedge(); op_done = 5'h00;
        nedge();
        chk("R4 last", 16'(op_start), 16'h10);
        op_done = 5'h10; nedge(); op_done = 5'h00;
        chk("R8 all done", 16'(rsp_rd), 16'h1F);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule